// File: doc/BRIEF.md
# Dual Window Supply Supervisor

This block is the digital core of a supervisor that watches two supply rails, each against a voltage window. Each rail forms one pair. A pair receives two comparator bits. The low-limit bit is 1 while the rail is above its lower limit. The high-limit bit is 1 while the rail is above its upper limit. Each pair also has its own enable. The comparator and enable bits arrive asynchronously. A synchronizer chain and a glitch filter clean them before they reach the status logic.

Each pair drives three registered outputs. The low status goes high only after the rail has stayed above its lower limit for a full stability period. The high status idles high and drops when the rail goes over its upper limit. After an excess it returns high only once the rail has stayed below the upper limit for a full stability period. Power-good is high only while both statuses are high. The filter time, the stability time and the synchronizer depth are parameters counted in clock cycles. The analog comparators, the divider resistors and the open-drain output stages sit outside this block.

Top module: `dual_window_supervisor`

## Requirements
- R1: The pairs are fully independent. An input change on one pair never changes the outputs of another pair. Bit i of every port belongs to pair i.
- R2: While the synchronous reset is high, and on the first cycle after it, every low status is 0, every high status is 1 and every power-good is 0.
- R3: A low status rises exactly SYNC_STAGES+FILT_CYC+STAB_CYC cycles after its low-limit input goes to 1 and stays there. Before that cycle it stays 0.
- R4: A power-good output is 1 only while the enable of its pair is on and both of its statuses are 1.
- R5: When the low-limit input of an enabled, compliant pair goes to 0 and stays there, the low status and power-good fall exactly SYNC_STAGES+FILT_CYC+1 cycles later. The high status stays 1.
- R6: When the high-limit input of an enabled, compliant pair goes to 1 and stays there, the high status and power-good fall exactly SYNC_STAGES+FILT_CYC+1 cycles later. The low status stays 1.
- R7: A comparator excursion that lasts fewer than FILT_CYC cycles changes no output.
- R8: Driving an enable to 0 forces that pair to low status 0, high status 1 and power-good 0, SYNC_STAGES+1 cycles later. Driving it back to 1 with a compliant rail restores power-good SYNC_STAGES+STAB_CYC cycles later.
- R9: After an over-limit fault, the high status returns to 1 only once the filtered high-limit input has been 0 for STAB_CYC consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_ok_i | input | N_PAIRS | Per pair: rail above lower limit (asynchronous) |
| hi_over_i | input | N_PAIRS | Per pair: rail above upper limit (asynchronous) |
| en_i | input | N_PAIRS | Per pair monitoring enable (asynchronous) |
| lo_stat_o | output | N_PAIRS | Per pair lower-limit status, 1 = satisfied |
| hi_stat_o | output | N_PAIRS | Per pair upper-limit status, 1 = satisfied (idles high) |
| pwr_good_o | output | N_PAIRS | Per pair power-good, 1 = rail inside window |

## Verification
The hardest state to reach from the ports is a pair whose enable returns while the high-limit input is still being filtered out of an over-limit level. In that state the high status can dip for a short time and then requalify over a full stability period, and the other pair must not move during any of it. The stimulus table reaches this state by disabling one pair while its rail is held over its upper limit. It then re-enables the pair with a compliant rail, while the second pair holds a steady in-window state. Directed sequences then measure the exact cycle of each fault drop, each qualification rise and each enable transition. They also apply excursions one cycle shorter than the filter time and check every cycle that nothing moves.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef struct packed {
    logic lo;
    logic hi;
    logic pg;
  } pair_stat_t;

  localparam pair_stat_t STAT_IDLE = '{lo: 1'b0, hi: 1'b1, pg: 1'b0};

  function automatic int cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ws_sync.sv
module ws_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ws_glitch_filter.sv
module ws_glitch_filter #(
  parameter int unsigned FILT_CYC = 4,
  parameter logic        RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int CW = ws_pkg::cnt_width(FILT_CYC);

  if (FILT_CYC <= 1) begin : g_pass
    always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= d;
    end
  end else begin : g_count
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        q   <= RST_VAL;
        cnt <= '0;
      end else if (d == q) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        q   <= d;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ws_qual_timer.sv
module ws_qual_timer #(
  parameter int unsigned CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic cond,
  output logic hit
);
  localparam int CW = ws_pkg::cnt_width(CYC);
  logic [CW-1:0] cnt;

  assign hit = cond && !clr && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || !cond) cnt <= '0;
    else if (hit)            cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ws_pair_status.sv
module ws_pair_status #(
  parameter int unsigned STAB_CYC = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_ok,
  input  logic                lo_ok,
  input  logic                hi_over,
  output ws_pkg::pair_stat_t  stat
);
  import ws_pkg::*;

  pair_stat_t stat_q, stat_n;
  logic       lo_hit, hi_hit;

  ws_qual_timer #(.CYC(STAB_CYC)) u_lo_tmr (
    .clk (clk), .rst (rst), .clr (!en_ok),
    .cond(lo_ok && !stat_q.lo), .hit (lo_hit)
  );

  ws_qual_timer #(.CYC(STAB_CYC)) u_hi_tmr (
    .clk (clk), .rst (rst), .clr (!en_ok),
    .cond(!hi_over && !stat_q.hi), .hit (hi_hit)
  );

  always_comb begin
    if (!en_ok) begin
      stat_n.lo = 1'b0;
      stat_n.hi = 1'b1;
    end else begin
      stat_n.lo = stat_q.lo ? lo_ok    : lo_hit;
      stat_n.hi = stat_q.hi ? !hi_over : hi_hit;
    end
    stat_n.pg = en_ok && stat_n.lo && stat_n.hi;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= STAT_IDLE;
    else     stat_q <= stat_n;
  end

  assign stat = stat_q;
endmodule

// File: rtl/dual_window_supervisor.sv
module dual_window_supervisor #(
  parameter int unsigned N_PAIRS     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 6000,
  parameter int unsigned STAB_CYC    = 32000000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PAIRS-1:0] lo_ok_i,
  input  logic [N_PAIRS-1:0] hi_over_i,
  input  logic [N_PAIRS-1:0] en_i,
  output logic [N_PAIRS-1:0] lo_stat_o,
  output logic [N_PAIRS-1:0] hi_stat_o,
  output logic [N_PAIRS-1:0] pwr_good_o
);
  logic [N_PAIRS-1:0] en_q, lo_filt, hi_filt;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    logic [2:0]         raw_q;
    ws_pkg::pair_stat_t stat;

    ws_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst),
      .d  ({en_i[p], hi_over_i[p], lo_ok_i[p]}),
      .q  (raw_q)
    );

    assign en_q[p] = raw_q[2];

    ws_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b0)) u_lo_filt (
      .clk(clk), .rst(rst), .d(raw_q[0]), .q(lo_filt[p])
    );

    ws_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b0)) u_hi_filt (
      .clk(clk), .rst(rst), .d(raw_q[1]), .q(hi_filt[p])
    );

    ws_pair_status #(.STAB_CYC(STAB_CYC)) u_stat (
      .clk    (clk),
      .rst    (rst),
      .en_ok  (en_q[p]),
      .lo_ok  (lo_filt[p]),
      .hi_over(hi_filt[p]),
      .stat   (stat)
    );

    assign lo_stat_o[p]  = stat.lo;
    assign hi_stat_o[p]  = stat.hi;
    assign pwr_good_o[p] = stat.pg;
  end
endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
  parameter int unsigned N_PAIRS  = 2,
  parameter int unsigned STAB_CYC = 20
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PAIRS-1:0] en_q,
  input logic [N_PAIRS-1:0] lo_filt,
  input logic [N_PAIRS-1:0] hi_filt,
  input logic [N_PAIRS-1:0] lo_stat_o,
  input logic [N_PAIRS-1:0] hi_stat_o,
  input logic [N_PAIRS-1:0] pwr_good_o
);
  localparam int CW = ws_pkg::cnt_width(STAB_CYC);

  p_reset_state_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lo_stat_o == '0 && hi_stat_o == '1 && pwr_good_o == '0));

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_chk
    logic [CW-1:0] lo_run, hi_run;

    always_ff @(posedge clk) begin
      if (rst || !(lo_filt[p] && en_q[p])) lo_run <= '0;
      else if (lo_run != CW'(STAB_CYC))    lo_run <= lo_run + 1'b1;
      if (rst || !(!hi_filt[p] && en_q[p])) hi_run <= '0;
      else if (hi_run != CW'(STAB_CYC))     hi_run <= hi_run + 1'b1;
    end

    p_pg_window_r4: assert property (@(posedge clk) disable iff (rst)
      pwr_good_o[p] |-> (lo_stat_o[p] && hi_stat_o[p]));

    p_disable_forced_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(en_q[p]) |-> (!pwr_good_o[p] && !lo_stat_o[p] && hi_stat_o[p]));

    p_lo_qualified_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(lo_stat_o[p]) |-> (lo_run >= CW'(STAB_CYC)));

    p_hi_requalified_r9: assert property (@(posedge clk) disable iff (rst)
      ($rose(hi_stat_o[p]) && $past(en_q[p])) |-> (hi_run >= CW'(STAB_CYC)));
  end
endmodule

bind dual_window_supervisor ws_checker #(.N_PAIRS(N_PAIRS), .STAB_CYC(STAB_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .lo_filt   (lo_filt),
  .hi_filt   (hi_filt),
  .lo_stat_o (lo_stat_o),
  .hi_stat_o (hi_stat_o),
  .pwr_good_o(pwr_good_o)
);

// File: tb/dual_window_supervisor_tb.sv
`timescale 1ns/1ps
module dual_window_supervisor_tb;
  localparam int NP = 2;
  localparam int SY = 2;
  localparam int F  = 4;
  localparam int S  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] lo_ok = '0, hi_over = '0, en = '0;
  logic [NP-1:0] lo_stat, hi_stat, pg;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_window_supervisor #(.N_PAIRS(NP), .SYNC_STAGES(SY), .FILT_CYC(F), .STAB_CYC(S)) u_dut (
    .clk(clk), .rst(rst), .lo_ok_i(lo_ok), .hi_over_i(hi_over), .en_i(en),
    .lo_stat_o(lo_stat), .hi_stat_o(hi_stat), .pwr_good_o(pg)
  );

  // {en[1:0], lo[1:0], hi[1:0], hold[7:0], exp_lo[1:0], exp_hi[1:0], exp_pg[1:0]}
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {2'b11, 2'b01, 2'b00, 8'd40, 2'b01, 2'b11, 2'b01},  // R1 pair 1 under, pair 0 good
    {2'b11, 2'b11, 2'b01, 8'd40, 2'b11, 2'b10, 2'b10},  // R6 pair 0 over
    {2'b11, 2'b11, 2'b00, 8'd10, 2'b11, 2'b10, 2'b10},  // R9 not yet requalified
    {2'b11, 2'b11, 2'b00, 8'd30, 2'b11, 2'b11, 2'b11},  // R9 requalified
    {2'b11, 2'b10, 2'b00, 8'd40, 2'b10, 2'b11, 2'b10},  // R5 pair 0 under
    {2'b10, 2'b11, 2'b01, 8'd40, 2'b10, 2'b11, 2'b10},  // R8 disabled while over
    {2'b11, 2'b11, 2'b00, 8'd40, 2'b11, 2'b11, 2'b11},  // R8 re-enabled
    {2'b01, 2'b11, 2'b00, 8'd40, 2'b01, 2'b11, 2'b01},  // R1 R8 pair 1 disabled
    {2'b11, 2'b11, 2'b00, 8'd40, 2'b11, 2'b11, 2'b11},  // R8 pair 1 back
    {2'b11, 2'b00, 2'b11, 8'd40, 2'b00, 2'b00, 2'b00},  // R4 both limits failed
    {2'b11, 2'b11, 2'b00, 8'd40, 2'b11, 2'b11, 2'b11}   // R3 R9 recovered
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual lo/hi/pg=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] outs();
    return {lo_stat, hi_stat, pg};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitn(4);
    rst = 1'b0;
    waitn(1);
    chk("R2 reset state", outs(), {2'b00, 2'b11, 2'b00});

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      en = v[19:18]; lo_ok = v[17:16]; hi_over = v[15:14];
      waitn(int'(v[13:6]));
      chk($sformatf("R1/R3-R9 table vector %0d", i), outs(), v[5:0]);
    end

    // R7: short excursions on both pairs' inputs
    begin
      bit moved;
      moved = 1'b0;
      lo_ok[0] = 1'b0; hi_over[1] = 1'b1;
      waitn(F - 1);
      lo_ok[0] = 1'b1; hi_over[1] = 1'b0;
      for (int k = 0; k < 40; k++) begin
        waitn(1);
        if (outs() !== 6'b111111) moved = 1'b1;
      end
      chk("R7 glitch ignored", moved ? 6'b000000 : outs(), 6'b111111);
    end

    // R5 exact drop latency SY+F+1 = 7
    lo_ok[0] = 1'b0;
    waitn(SY + F);
    chk("R5 not before latency", outs(), 6'b111111);
    waitn(1);
    chk("R5 drop, hi stays", outs(), {2'b10, 2'b11, 2'b10});

    // R3 exact rise latency SY+F+S = 26
    waitn(30);
    lo_ok[0] = 1'b1;
    waitn(SY + F + S - 1);
    chk("R3 not before stability", outs(), {2'b10, 2'b11, 2'b10});
    waitn(1);
    chk("R3 qualified rise", outs(), 6'b111111);

    // R6 exact over latency on pair 1
    hi_over[1] = 1'b1;
    waitn(SY + F);
    chk("R6 not before latency", outs(), 6'b111111);
    waitn(1);
    chk("R6 over drop, lo stays", outs(), {2'b11, 2'b01, 2'b01});
    hi_over[1] = 1'b0;
    waitn(40);
    chk("R9 hi requalified", outs(), 6'b111111);

    // R8 enable timing on pair 0, pair 1 untouched (R1)
    en[0] = 1'b0;
    waitn(SY);
    chk("R8 not before disable latency", outs(), 6'b111111);
    waitn(1);
    chk("R8 disable forces idle", outs(), {2'b10, 2'b11, 2'b10});
    en[0] = 1'b1;
    waitn(SY + S - 1);
    chk("R8 R1 re-enable not early", outs(), {2'b10, 2'b11, 2'b10});
    waitn(1);
    chk("R8 re-enable restores pg", outs(), 6'b111111);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule